// File: doc/BRIEF.md
# Sprite vertical shrink line mapper

This block turns the line of a sprite that is being drawn into the tilemap slot to read and the row inside that tile to fetch. The vertical shrink comes from an external byte lookup memory that holds one 256-entry table for each vertical zoom value. For every request the block forms a lookup address from the zoom value and the sprite line. When the memory returns the byte, the block decodes it into a slot and a row. A sprite is 512 lines tall. The lower half reuses the table of the upper half by walking it backwards, and it mirrors the decoded fields.

A request is a one-cycle start strobe with the current scanline, the sprite Y position and the zoom value. The block presents the address and a read strobe in that same cycle. The memory answers with a fixed latency of one or two clocks. The decoded result appears one registered stage later, together with a valid flag. A request may be issued on every clock. When consecutive lines read the same table byte they give identical outputs. This is how the table repeats lines and drops lines to shrink the sprite.

Top module: `sprite_vshrink_mapper`

## Requirements
- R1: In any cycle in which `start` is high, `mem_rd` is high and `mem_addr[15:8]` equals `zoom`. With zoom 0x1B and sprite line 0, the address is 0x1B00.
- R2: The sprite line is (`scanline` − `ypos`) modulo 512. Bit 8 of the line selects the half, where 0 is top and 1 is bottom. In the top half, `mem_addr[7:0]` equals line bits 7:0.
- R3: In the bottom half, `mem_addr[7:0]` equals the bitwise complement of line bits 7:0, so the table is read in reverse.
- R4: For a top-half request, `out_slot` equals returned byte bits 7:4, in the range 0 to 15, and `out_row` equals byte bits 3:0. For example, byte 0x08 gives slot 0 and row 8, and byte 0xE8 gives slot 14 and row 8.
- R5: For a bottom-half request, `out_slot` equals byte bits 7:4 XOR 0x1F, in the range 16 to 31, and `out_row` equals byte bits 3:0 XOR 0xF.
- R6: `out_valid` is high exactly RD_LAT+1 cycles after each cycle with `start` high and is low otherwise. A start is accepted on every clock.
- R7: The half of each request travels with its read. When requests from the two halves are interleaved cycle by cycle, each returned byte is decoded with the masks of its own half.
- R8: When `out_valid` is low, `out_slot` and `out_row` keep their last values. Consecutive lines that return the same byte produce the same slot and row. With zoom 0x1B, lines 28 and 29 both return 0xFF, which gives slot 15 and row 15.
- R9: A synchronous reset clears `out_valid`, `out_slot` and `out_row` to zero and discards every request in flight. Starts issued during reset produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe for one line |
| scanline | input | 9 | Current scanline |
| ypos | input | 9 | Sprite Y position |
| zoom | input | 8 | Vertical zoom value, selects the table |
| mem_rd | output | 1 | Lookup read strobe |
| mem_addr | output | 16 | Lookup address, zoom in the high byte and line index in the low byte |
| mem_data | input | 8 | Byte returned RD_LAT cycles after the read |
| out_valid | output | 1 | Decoded result valid |
| out_slot | output | 5 | Tilemap slot index, 0 to 31 |
| out_row | output | 4 | Row within the tile, 0 to 15 |

## Verification
Two things can meet in one cycle: a new address is issued for one half while a byte for the other half is being decoded. If the half bit is not delayed to match the read, the wrong XOR masks are applied. The bench provokes this by streaming a start on every clock across the 255/256 and 511/0 line boundaries, and by alternating top and bottom lines on successive clocks. It judges each output against a slot and row computed from the half of the request that produced it. A reset dropped onto a full pipeline also checks that the outputs clear in the same edge that would otherwise load a result.

// File: rtl/vshrink_pkg.sv
`timescale 1ns/1ps
package vshrink_pkg;
   typedef enum logic {
      HALF_TOP    = 1'b0,
      HALF_BOTTOM = 1'b1
   } half_e;

   localparam int LAT_MIN = 1;
   localparam int LAT_MAX = 2;
endpackage

// File: rtl/vshrink_addr_gen.sv
`timescale 1ns/1ps
module vshrink_addr_gen import vshrink_pkg::*; #(
   parameter  int ZOOM_W = 8,
   parameter  int IDX_W  = 8,
   localparam int LINE_W = IDX_W + 1,
   localparam int ADDR_W = ZOOM_W + IDX_W
) (
   input  logic [LINE_W-1:0] scanline,
   input  logic [LINE_W-1:0] ypos,
   input  logic [ZOOM_W-1:0] zoom,
   output logic [ADDR_W-1:0] addr,
   output half_e             half
);
   logic [LINE_W-1:0] line_num;
   logic [IDX_W-1:0]  idx;

   always_comb begin
      line_num = scanline - ypos;
      half     = half_e'(line_num[LINE_W-1]);
      idx      = (half == HALF_BOTTOM) ? ~line_num[IDX_W-1:0] : line_num[IDX_W-1:0];
      addr     = {zoom, idx};
   end
endmodule

// File: rtl/vshrink_tag_pipe.sv
`timescale 1ns/1ps
module vshrink_tag_pipe import vshrink_pkg::*; #(
   parameter int RD_LAT = 1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  in_vld,
   input  half_e in_half,
   output logic  out_vld,
   output half_e out_half
);
   logic [RD_LAT-1:0] vld_sr;
   logic [RD_LAT-1:0] half_sr;

   generate
      if (RD_LAT == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) begin
               vld_sr  <= '0;
               half_sr <= '0;
            end else begin
               vld_sr  <= in_vld;
               half_sr <= in_half;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) begin
               vld_sr  <= '0;
               half_sr <= '0;
            end else begin
               vld_sr  <= {vld_sr[RD_LAT-2:0], in_vld};
               half_sr <= {half_sr[RD_LAT-2:0], in_half};
            end
         end
      end
   endgenerate

   assign out_vld  = vld_sr[RD_LAT-1];
   assign out_half = half_e'(half_sr[RD_LAT-1]);
endmodule

// File: rtl/vshrink_decode.sv
`timescale 1ns/1ps
module vshrink_decode import vshrink_pkg::*; #(
   parameter  int DATA_W = 8,
   localparam int NIB_W  = DATA_W / 2,
   localparam int SLOT_W = NIB_W + 1
) (
   input  logic [DATA_W-1:0] data,
   input  half_e             half,
   output logic [SLOT_W-1:0] slot,
   output logic [NIB_W-1:0]  row
);
   localparam logic [SLOT_W-1:0] SLOT_MASK = {SLOT_W{1'b1}};
   localparam logic [NIB_W-1:0]  ROW_MASK  = {NIB_W{1'b1}};

   logic [SLOT_W-1:0] slot_raw;
   logic [NIB_W-1:0]  row_raw;

   always_comb begin
      slot_raw = {1'b0, data[DATA_W-1:NIB_W]};
      row_raw  = data[NIB_W-1:0];
      if (half == HALF_BOTTOM) begin
         slot = slot_raw ^ SLOT_MASK;
         row  = row_raw ^ ROW_MASK;
      end else begin
         slot = slot_raw;
         row  = row_raw;
      end
   end
endmodule

// File: rtl/sprite_vshrink_mapper.sv
`timescale 1ns/1ps
module sprite_vshrink_mapper import vshrink_pkg::*; #(
   parameter  int ZOOM_W = 8,
   parameter  int IDX_W  = 8,
   parameter  int DATA_W = 8,
   parameter  int RD_LAT = 1,
   localparam int LINE_W = IDX_W + 1,
   localparam int ADDR_W = ZOOM_W + IDX_W,
   localparam int NIB_W  = DATA_W / 2,
   localparam int SLOT_W = NIB_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [LINE_W-1:0] scanline,
   input  logic [LINE_W-1:0] ypos,
   input  logic [ZOOM_W-1:0] zoom,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   output logic              out_valid,
   output logic [SLOT_W-1:0] out_slot,
   output logic [NIB_W-1:0]  out_row
);
   generate
      if (RD_LAT < LAT_MIN || RD_LAT > LAT_MAX) begin : g_bad_lat
         $error("RD_LAT must be 1 or 2");
      end
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data
         $error("DATA_W must be even and at least 2");
      end
      if (IDX_W < 1 || ZOOM_W < 1) begin : g_bad_idx
         $error("IDX_W and ZOOM_W must be positive");
      end
   endgenerate

   half_e             req_half;
   logic              tag_vld;
   half_e             tag_half;
   logic [SLOT_W-1:0] dec_slot;
   logic [NIB_W-1:0]  dec_row;

   vshrink_addr_gen #(.ZOOM_W(ZOOM_W), .IDX_W(IDX_W)) u_addr (
      .scanline (scanline),
      .ypos     (ypos),
      .zoom     (zoom),
      .addr     (mem_addr),
      .half     (req_half)
   );

   assign mem_rd = start;

   vshrink_tag_pipe #(.RD_LAT(RD_LAT)) u_tag (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (start),
      .in_half  (req_half),
      .out_vld  (tag_vld),
      .out_half (tag_half)
   );

   vshrink_decode #(.DATA_W(DATA_W)) u_dec (
      .data (mem_data),
      .half (tag_half),
      .slot (dec_slot),
      .row  (dec_row)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_slot  <= '0;
         out_row   <= '0;
      end else begin
         out_valid <= tag_vld;
         if (tag_vld) begin
            out_slot <= dec_slot;
            out_row  <= dec_row;
         end
      end
   end
endmodule

// File: rtl/vshrink_mapper_chk.sv
`timescale 1ns/1ps
module vshrink_mapper_chk #(
   parameter  int ZOOM_W = 8,
   parameter  int IDX_W  = 8,
   parameter  int DATA_W = 8,
   parameter  int RD_LAT = 1,
   localparam int LINE_W = IDX_W + 1,
   localparam int ADDR_W = ZOOM_W + IDX_W,
   localparam int NIB_W  = DATA_W / 2,
   localparam int SLOT_W = NIB_W + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic [LINE_W-1:0] scanline,
   input logic [LINE_W-1:0] ypos,
   input logic [ZOOM_W-1:0] zoom,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              tag_vld,
   input logic              tag_half,
   input logic              out_valid,
   input logic [SLOT_W-1:0] out_slot,
   input logic [NIB_W-1:0]  out_row
);
   logic [LINE_W-1:0] chk_line;
   assign chk_line = scanline - ypos;

   AST_ZOOM_IN_ADDR: assert property (@(posedge clk) disable iff (rst)
      start |-> (mem_rd && mem_addr[ADDR_W-1:IDX_W] == zoom)); // R1

   AST_TOP_INDEX: assert property (@(posedge clk) disable iff (rst)
      (start && !chk_line[LINE_W-1]) |-> (mem_addr[IDX_W-1:0] == chk_line[IDX_W-1:0])); // R2

   AST_BOTTOM_INDEX: assert property (@(posedge clk) disable iff (rst)
      (start && chk_line[LINE_W-1]) |-> ((mem_addr[IDX_W-1:0] ^ chk_line[IDX_W-1:0]) == {IDX_W{1'b1}})); // R3

   AST_VALID_STAGE: assert property (@(posedge clk) disable iff (rst)
      tag_vld |=> out_valid); // R6

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
      !tag_vld |=> !out_valid); // R6

   AST_HALF_TO_SLOT: assert property (@(posedge clk) disable iff (rst)
      tag_vld |=> (out_slot[SLOT_W-1] == $past(tag_half))); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !tag_vld |=> ($stable(out_slot) && $stable(out_row))); // R8

   AST_RESET_CLEARS: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && out_slot == '0 && out_row == '0)); // R9
endmodule

bind sprite_vshrink_mapper vshrink_mapper_chk #(
   .ZOOM_W(ZOOM_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .scanline  (scanline),
   .ypos      (ypos),
   .zoom      (zoom),
   .mem_rd    (mem_rd),
   .mem_addr  (mem_addr),
   .tag_vld   (tag_vld),
   .tag_half  (tag_half),
   .out_valid (out_valid),
   .out_slot  (out_slot),
   .out_row   (out_row)
);

// File: tb/sprite_vshrink_mapper_test.sv
`timescale 1ns/1ps
module sprite_vshrink_mapper_test;
   localparam int LAT = 1;

   logic        clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [8:0]  scanline = '0;
   logic [8:0]  ypos = '0;
   logic [7:0]  zoom = '0;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [7:0]  mem_data;
   logic [7:0]  d1 = '0;
   logic [7:0]  d2 = '0;
   logic        out_valid;
   logic [4:0]  out_slot;
   logic [3:0]  out_row;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic       hv [0:3];
   logic [4:0] hs [0:3];
   logic [3:0] hr [0:3];
   logic [4:0] last_s = '0;
   logic [3:0] last_r = '0;

   sprite_vshrink_mapper #(.RD_LAT(LAT)) uut (
      .clk(clk), .rst(rst), .start(start), .scanline(scanline), .ypos(ypos),
      .zoom(zoom), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
      .out_valid(out_valid), .out_slot(out_slot), .out_row(out_row)
   );

   function automatic logic [7:0] tbl(input logic [15:0] a);
      logic [7:0] i;
      i = a[7:0];
      if (a[15:8] == 8'h1B) begin
         if (i == 8'd0)  return 8'h00;
         if (i == 8'd1)  return 8'h08;
         if (i == 8'd2)  return 8'h10;
         if (i == 8'd26) return 8'hE8;
         if (i == 8'd27) return 8'hF8;
         if (i >= 8'd28) return 8'hFF;
      end
      return 8'((a * 167) ^ (a >> 5) ^ (a[15:8] * 13));
   endfunction

   always @(posedge clk) begin
      d1 <= tbl(mem_addr);
      d2 <= d1;
   end
   assign mem_data = (LAT == 1) ? d1 : d2;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit r, input bit s, input int sc, input int y, input int z, input string ctx);
      logic [8:0]  ln;
      logic [7:0]  idx;
      logic [15:0] ea;
      logic [7:0]  d;
      string       ftag;
      @(negedge clk);
      if (hv[LAT]) begin
         ftag = hs[LAT][4] ? "R5" : "R4";
         chk(out_valid == 1'b1, {"R6 ", ctx}, "out_valid", int'(out_valid), 1);
         chk(out_slot == hs[LAT], {ftag, " ", ctx}, "out_slot", int'(out_slot), int'(hs[LAT]));
         chk(out_row == hr[LAT], {ftag, " ", ctx}, "out_row", int'(out_row), int'(hr[LAT]));
         last_s = hs[LAT];
         last_r = hr[LAT];
      end else begin
         chk(out_valid == 1'b0, {"R6 ", ctx}, "out_valid", int'(out_valid), 0);
         chk(out_slot == last_s, {"R8 ", ctx}, "held out_slot", int'(out_slot), int'(last_s));
         chk(out_row == last_r, {"R8 ", ctx}, "held out_row", int'(out_row), int'(last_r));
      end
      rst = r;
      start = s;
      scanline = 9'(sc);
      ypos = 9'(y);
      zoom = 8'(z);
      ln = 9'(sc - y);
      idx = ln[8] ? ~ln[7:0] : ln[7:0];
      ea = {8'(z), idx};
      #1;
      if (s) begin
         chk(mem_rd == 1'b1 && mem_addr[15:8] == 8'(z), "R1", "zoom byte", int'(mem_addr[15:8]), z);
         chk(mem_addr[7:0] == idx, ln[8] ? "R3" : "R2", "line index", int'(mem_addr[7:0]), int'(idx));
      end
      if (r) begin
         for (int i = 0; i < 4; i++) hv[i] = 1'b0;
         last_s = '0;
         last_r = '0;
      end
      for (int i = 3; i > 0; i--) begin
         hv[i] = hv[i-1];
         hs[i] = hs[i-1];
         hr[i] = hr[i-1];
      end
      d = tbl(ea);
      hv[0] = s && !r;
      hs[0] = ln[8] ? ({1'b0, d[7:4]} ^ 5'h1F) : {1'b0, d[7:4]};
      hr[0] = ln[8] ? (d[3:0] ^ 4'hF) : d[3:0];
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         hv[i] = 1'b0;
         hs[i] = '0;
         hr[i] = '0;
      end
      // R9: reset with starts pending
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 5, 0, 8'h1B, "R9 in reset");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 0, 0, "R9 after reset");
      // R1 R2 R3 R4: full sweep at zoom 0x1B, start every clock across both half boundaries
      for (int l = 0; l < 512; l++) step(1'b0, 1'b1, l, 0, 8'h1B, (l == 28 || l == 29) ? "R8 repeat" : "sweep A");
      for (int l = 0; l < 4; l++) step(1'b0, 1'b0, 0, 0, 0, "drain");
      // R8: gaps between requests, offset Y with wrap
      for (int l = 0; l < 512; l++) step(1'b0, (l % 3) != 2, l, 300, 8'hFF, "R8 gaps");
      // R7: interleave top and bottom halves every cycle
      for (int l = 0; l < 256; l++) begin
         step(1'b0, 1'b1, l, 511, 8'h00, "R7 mixed top");
         step(1'b0, 1'b1, l + 256, 511, 8'h00, "R7 mixed bottom");
      end
      for (int l = 0; l < 4; l++) step(1'b0, 1'b0, 0, 0, 0, "drain");
      // R9: reset dropped onto a full pipeline
      for (int l = 0; l < 6; l++) step(1'b0, 1'b1, l + 250, 0, 8'h42, "R9 prefill");
      step(1'b1, 1'b1, 260, 0, 8'h42, "R9 mid reset");
      for (int l = 0; l < 4; l++) step(1'b0, 1'b0, 0, 0, 0, "R9 post reset");
      for (int l = 0; l < 8; l++) step(1'b0, 1'b1, l * 61, 17, 8'h80, "R6 restart");
      for (int l = 0; l < 4; l++) step(1'b0, 1'b0, 0, 0, 0, "drain");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule